// File: doc/BRIEF.md
# MSI Snooping Coherence Controller

This block tracks the coherence state of every line in a small direct-mapped cache. It uses three states: Modified, Shared and Invalid. It answers processor read and write requests. When a request needs other caches to act, it issues a bus transaction. It also reacts to transactions that other caches place on a shared bus, which this block observes (snoops). Only the state bookkeeping and the ordering of transactions are modelled. Data storage, memory latency, arbitration between caches and replacement writebacks are left to neighbouring blocks.

A processor request is held valid until `cpu_ready` rises. A request that can be served locally is answered in the cycle it is presented, and `cpu_hit` rises with `cpu_ready`. A request that needs the bus moves the controller to a request phase, in which it raises `bus_req_valid` with a command. After the grant it waits for `bus_done`, and answers the processor in that completion cycle. On the snoop side, a snooped transaction arrives as a single-cycle `snp_valid` pulse. If this cache holds the line dirty, `snp_flush` rises in the same cycle.

Top module: `msi_coh_ctrl`

## Requirements
- R1: After reset, every line is Invalid. `cpu_ready`, `cpu_hit`, `bus_req_valid` and `snp_flush` are low, and `bus_req_cmd` is 0 (no command).
- R2: A read to a line in Modified or Shared raises `cpu_ready` and `cpu_hit` in the same cycle. It issues no bus request and leaves the state unchanged.
- R3: A read to an Invalid line issues BusRd (command code 1). When it completes, the line is Shared.
- R4: A write to a Modified line raises `cpu_ready` and `cpu_hit` in the same cycle, without bus activity. The line stays Modified.
- R5: A write to a Shared line issues BusUpgr (command code 3). When it completes, the line is Modified.
- R6: A write to an Invalid line issues BusRdX (command code 2). When it completes, the line is Modified.
- R7: A snooped BusRd on a Modified line raises `snp_flush` in the snoop cycle and leaves the line Shared. On a Shared line, it raises no flush and the line stays Shared.
- R8: A snooped BusRdX or BusUpgr on a Modified line raises `snp_flush` and leaves the line Invalid. On a Shared line, it leaves the line Invalid without a flush.
- R9: A snoop to an Invalid line raises no flush and leaves the line Invalid.
- R10: A bus request is raised one cycle after the request is accepted. Its valid and index stay steady until `bus_grant`, and `bus_req_valid` drops after the grant. `cpu_ready` stays low until the cycle of `bus_done`. In that cycle `cpu_ready` is high and `cpu_hit` is low, and the new state applies from the next cycle.
- R11: Suppose a BusUpgr is waiting for its grant and a snooped BusRdX or BusUpgr to the same index arrives. The request is then presented as BusRdX from that cycle on, including when the grant comes in the same cycle. A snoop to another index leaves the command unchanged.
- R12: When a snoop and a new processor request name the same index in the same cycle, the request is judged against the state left after the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present, held until `cpu_ready` |
| cpu_req_write | input | 1 | 1 = write, 0 = read |
| cpu_req_idx | input | IDX_W | Line index of the request |
| cpu_ready | output | 1 | Request finished this cycle |
| cpu_hit | output | 1 | Request finished locally, without the bus |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 1 BusRd, 2 BusRdX, 3 BusUpgr, 0 none |
| bus_req_idx | output | IDX_W | Line index of the bus transaction |
| bus_grant | input | 1 | Bus granted to this cache |
| bus_done | input | 1 | Granted transaction finished |
| snp_valid | input | 1 | Snooped transaction present |
| snp_cmd | input | 2 | Snooped command, same codes as `bus_req_cmd` |
| snp_idx | input | IDX_W | Line index of the snooped transaction |
| snp_flush | output | 1 | This cache must supply the dirty line |

## Verification
The hardest case to reach is a snoop that invalidates a line while that line's BusUpgr is still waiting for its grant. The stimulus brings the line to Shared through a read miss and then presents a write. It holds the grant back, and injects a snooped BusUpgr to the same index while the request is up. This is done once with a later grant and once with the grant in the same cycle as the snoop, and both times the command is observed on the request port. Every line is also swept through every starting state, under every processor operation and every snooped command. A bench model of the expected states checks each answer, along with the command and flush outputs.

// File: rtl/msi_pkg.sv
package msi_pkg;

   typedef enum logic [1:0] {
      LN_INV = 2'd0,
      LN_SHD = 2'd1,
      LN_MOD = 2'd2
   } line_st_e;

   typedef enum logic [1:0] {
      XC_NONE = 2'd0,
      XC_RD   = 2'd1,
      XC_RDX  = 2'd2,
      XC_UPGR = 2'd3
   } xact_e;

   // State a line takes after another cache's transaction is observed
   function automatic line_st_e snoop_next(line_st_e cur, xact_e cmd);
      line_st_e nxt;
      nxt = cur;
      case (cmd)
         XC_RD:           if (cur == LN_MOD) nxt = LN_SHD;
         XC_RDX, XC_UPGR: nxt = LN_INV;
         default:         nxt = cur;
      endcase
      return nxt;
   endfunction

   // A dirty line must be supplied for any observed transaction
   function automatic logic snoop_dirty(line_st_e cur, xact_e cmd);
      return (cur == LN_MOD) && (cmd != XC_NONE);
   endfunction

endpackage

// File: rtl/msi_tag_array.sv
module msi_tag_array
   import msi_pkg::*;
#(
   parameter int NUM_LINES = 8,
   parameter int IDX_W     = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             snp_valid,
   input  xact_e            snp_cmd,
   input  logic [IDX_W-1:0] snp_idx,
   input  logic             upd_valid,
   input  logic [IDX_W-1:0] upd_idx,
   input  line_st_e         upd_state,
   input  logic [IDX_W-1:0] look_idx,
   output line_st_e         look_state,
   output logic             snp_flush
);

   line_st_e tag_q [NUM_LINES];
   line_st_e snp_line;

   for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tag_q[g] <= LN_INV;
         end else if (upd_valid && (upd_idx == IDX_W'(g))) begin
            tag_q[g] <= upd_state;
         end else if (snp_valid && (snp_idx == IDX_W'(g))) begin
            tag_q[g] <= snoop_next(tag_q[g], snp_cmd);
         end
      end
   end

   always_comb begin
      snp_line  = tag_q[snp_idx];
      snp_flush = snp_valid && snoop_dirty(snp_line, snp_cmd);
      // same-index snoop is applied before the processor lookup
      if (snp_valid && (snp_idx == look_idx)) begin
         look_state = snoop_next(tag_q[look_idx], snp_cmd);
      end else begin
         look_state = tag_q[look_idx];
      end
   end

endmodule

// File: rtl/msi_req_seq.sv
module msi_req_seq
   import msi_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req_valid,
   input  logic             cpu_req_write,
   input  logic [IDX_W-1:0] cpu_req_idx,
   input  line_st_e         look_state,
   input  logic             bus_grant,
   input  logic             bus_done,
   input  logic             snp_valid,
   input  xact_e            snp_cmd,
   input  logic [IDX_W-1:0] snp_idx,
   output logic             cpu_ready,
   output logic             cpu_hit,
   output logic             bus_req_valid,
   output xact_e            bus_req_cmd,
   output logic [IDX_W-1:0] bus_req_idx,
   output logic             upd_valid,
   output logic [IDX_W-1:0] upd_idx,
   output line_st_e         upd_state
);

   typedef enum logic [1:0] {SQ_IDLE, SQ_REQ, SQ_WAIT} seq_e;

   seq_e             seq_q;
   xact_e            cmd_q;
   xact_e            cmd_eff;
   xact_e            miss_cmd;
   logic [IDX_W-1:0] idx_q;
   logic             wr_q;
   logic             local_hit;
   logic             snp_kill;

   always_comb begin
      local_hit = cpu_req_valid &&
                  ((look_state == LN_MOD) ||
                   (!cpu_req_write && (look_state == LN_SHD)));
      if (!cpu_req_write)             miss_cmd = XC_RD;
      else if (look_state == LN_SHD)  miss_cmd = XC_UPGR;
      else                            miss_cmd = XC_RDX;

      snp_kill = snp_valid && (snp_idx == idx_q) &&
                 ((snp_cmd == XC_RDX) || (snp_cmd == XC_UPGR));
      cmd_eff  = ((cmd_q == XC_UPGR) && snp_kill) ? XC_RDX : cmd_q;

      bus_req_valid = (seq_q == SQ_REQ);
      bus_req_cmd   = (seq_q == SQ_REQ) ? cmd_eff : XC_NONE;
      bus_req_idx   = idx_q;

      cpu_hit   = (seq_q == SQ_IDLE) && local_hit;
      cpu_ready = cpu_hit || ((seq_q == SQ_WAIT) && bus_done);

      upd_valid = (seq_q == SQ_WAIT) && bus_done;
      upd_idx   = idx_q;
      upd_state = wr_q ? LN_MOD : LN_SHD;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seq_q <= SQ_IDLE;
         cmd_q <= XC_NONE;
         idx_q <= '0;
         wr_q  <= 1'b0;
      end else begin
         case (seq_q)
            SQ_IDLE: if (cpu_req_valid && !local_hit) begin
               seq_q <= SQ_REQ;
               cmd_q <= miss_cmd;
               idx_q <= cpu_req_idx;
               wr_q  <= cpu_req_write;
            end
            SQ_REQ: begin
               cmd_q <= cmd_eff;
               if (bus_grant) seq_q <= SQ_WAIT;
            end
            SQ_WAIT: if (bus_done) seq_q <= SQ_IDLE;
            default: seq_q <= SQ_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/msi_coh_ctrl.sv
module msi_coh_ctrl
   import msi_pkg::*;
#(
   parameter  int NUM_LINES = 8,
   localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_req_valid,
   input  logic             cpu_req_write,
   input  logic [IDX_W-1:0] cpu_req_idx,
   output logic             cpu_ready,
   output logic             cpu_hit,
   output logic             bus_req_valid,
   output logic [1:0]       bus_req_cmd,
   output logic [IDX_W-1:0] bus_req_idx,
   input  logic             bus_grant,
   input  logic             bus_done,
   input  logic             snp_valid,
   input  logic [1:0]       snp_cmd,
   input  logic [IDX_W-1:0] snp_idx,
   output logic             snp_flush
);

   if ((NUM_LINES < 2) || ((1 << IDX_W) != NUM_LINES)) begin : g_bad_cfg
      $error("NUM_LINES must be a power of two of at least 2");
   end

   line_st_e look_state;
   line_st_e upd_state;
   logic     upd_valid;
   logic [IDX_W-1:0] upd_idx;
   xact_e    snp_cmd_e;
   xact_e    req_cmd_e;

   assign snp_cmd_e   = xact_e'(snp_cmd);
   assign bus_req_cmd = req_cmd_e;

   msi_tag_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_tags (
      .clk        (clk),
      .rst_n      (rst_n),
      .snp_valid  (snp_valid),
      .snp_cmd    (snp_cmd_e),
      .snp_idx    (snp_idx),
      .upd_valid  (upd_valid),
      .upd_idx    (upd_idx),
      .upd_state  (upd_state),
      .look_idx   (cpu_req_idx),
      .look_state (look_state),
      .snp_flush  (snp_flush)
   );

   msi_req_seq #(.IDX_W(IDX_W)) u_seq (
      .clk           (clk),
      .rst_n         (rst_n),
      .cpu_req_valid (cpu_req_valid),
      .cpu_req_write (cpu_req_write),
      .cpu_req_idx   (cpu_req_idx),
      .look_state    (look_state),
      .bus_grant     (bus_grant),
      .bus_done      (bus_done),
      .snp_valid     (snp_valid),
      .snp_cmd       (snp_cmd_e),
      .snp_idx       (snp_idx),
      .cpu_ready     (cpu_ready),
      .cpu_hit       (cpu_hit),
      .bus_req_valid (bus_req_valid),
      .bus_req_cmd   (req_cmd_e),
      .bus_req_idx   (bus_req_idx),
      .upd_valid     (upd_valid),
      .upd_idx       (upd_idx),
      .upd_state     (upd_state)
   );

endmodule

// File: rtl/msi_coh_chk.sv
module msi_coh_chk #(
   parameter int IDX_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cpu_req_valid,
   input logic             cpu_ready,
   input logic             cpu_hit,
   input logic             bus_req_valid,
   input logic [1:0]       bus_req_cmd,
   input logic [IDX_W-1:0] bus_req_idx,
   input logic             bus_grant,
   input logic             snp_valid,
   input logic [1:0]       snp_cmd,
   input logic             snp_flush
);

   // R7
   flush_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush |-> (snp_valid && (snp_cmd != 2'd0)));

   // R2
   hit_is_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_hit |-> (cpu_ready && cpu_req_valid));

   // R10
   req_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_grant) |=> (bus_req_valid && $stable(bus_req_idx)));

   // R10
   req_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && bus_grant) |=> !bus_req_valid);

   // R10
   no_ready_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> !cpu_ready);

   // R3
   cmd_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req_valid |-> (bus_req_cmd != 2'd0));

   // R11
   no_upgr_after_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req_valid && !bus_grant && (bus_req_cmd == 2'd2)) |=>
      (bus_req_valid && (bus_req_cmd == 2'd2)));

endmodule

bind msi_coh_ctrl msi_coh_chk #(.IDX_W(IDX_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cpu_req_valid (cpu_req_valid),
   .cpu_ready     (cpu_ready),
   .cpu_hit       (cpu_hit),
   .bus_req_valid (bus_req_valid),
   .bus_req_cmd   (bus_req_cmd),
   .bus_req_idx   (bus_req_idx),
   .bus_grant     (bus_grant),
   .snp_valid     (snp_valid),
   .snp_cmd       (snp_cmd),
   .snp_flush     (snp_flush)
);

// File: tb/msi_coh_ctrl_bench.sv
`timescale 1ns/1ps
module msi_coh_ctrl_bench;

   localparam int NL = 8;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req_valid = 1'b0;
   logic          cpu_req_write = 1'b0;
   logic [IW-1:0] cpu_req_idx = '0;
   logic          cpu_ready, cpu_hit, bus_req_valid, snp_flush;
   logic [1:0]    bus_req_cmd;
   logic [IW-1:0] bus_req_idx;
   logic          bus_grant = 1'b0;
   logic          bus_done = 1'b0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'd0;
   logic [IW-1:0] snp_idx = '0;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  reported = 1'b0;
   logic [1:0] model [NL];   // 0 Invalid, 1 Shared, 2 Modified

   always #4 clk = ~clk;

   msi_coh_ctrl #(.NUM_LINES(NL)) u_msi_coh_ctrl (.*);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
   endtask

   // processor request, with gdly cycles of grant delay when the bus is needed
   task automatic cpu_op(input bit w, input int idx, input int gdly);
      logic [1:0] st;
      bit hit;
      logic [1:0] ecmd;
      string tag;
      st   = model[idx];
      hit  = (st == 2'd2) || (!w && st == 2'd1);
      ecmd = w ? ((st == 2'd1) ? 2'd3 : 2'd2) : 2'd1;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = w; cpu_req_idx = IW'(idx);
      #1;
      if (hit) begin
         tag = w ? "R4 write hit" : "R2 read hit";
         chk(tag, {cpu_ready, cpu_hit, bus_req_valid}, 3'b110);
         @(negedge clk);
         cpu_req_valid = 1'b0;
      end else begin
         tag = !w ? "R3 read miss" : ((st == 2'd1) ? "R5 write shared" : "R6 write invalid");
         chk(tag, {cpu_ready, cpu_hit}, 2'b00);
         @(negedge clk); #1;
         chk(tag, {bus_req_valid, bus_req_cmd, bus_req_idx}, {1'b1, ecmd, IW'(idx)});
         for (int k = 0; k < gdly; k++) begin
            @(negedge clk); #1;
            chk("R10 held before grant", {bus_req_valid, bus_req_idx, cpu_ready},
                {1'b1, IW'(idx), 1'b0});
         end
         bus_grant = 1'b1;
         @(negedge clk);
         bus_grant = 1'b0; #1;
         chk("R10 after grant", {bus_req_valid, cpu_ready}, 2'b00);
         bus_done = 1'b1; #1;
         chk("R10 completion", {cpu_ready, cpu_hit}, 2'b10);
         @(negedge clk);
         bus_done = 1'b0; cpu_req_valid = 1'b0;
         model[idx] = w ? 2'd2 : 2'd1;
      end
   endtask

   task automatic snoop_op(input logic [1:0] c, input int idx);
      string tag;
      logic [1:0] st;
      st  = model[idx];
      tag = (st == 2'd0) ? "R9 snoop invalid" : ((c == 2'd1) ? "R7 snoop read" : "R8 snoop excl");
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = c; snp_idx = IW'(idx);
      #1;
      chk(tag, snp_flush, (st == 2'd2));
      @(negedge clk);
      snp_valid = 1'b0;
      if (c != 2'd1) model[idx] = 2'd0;
      else if (st == 2'd2) model[idx] = 2'd1;
   endtask

   task automatic set_state(input int idx, input logic [1:0] s);
      snoop_op(2'd2, idx);
      if (s >= 2'd1) cpu_op(1'b0, idx, 0);
      if (s == 2'd2) cpu_op(1'b1, idx, 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      for (int i = 0; i < NL; i++) model[i] = 2'd0;
      repeat (3) @(negedge clk);
      #1;
      chk("R1 reset outputs", {cpu_ready, cpu_hit, bus_req_valid, bus_req_cmd, snp_flush}, 6'd0);
      rst_n = 1'b1;
      @(negedge clk); #1;
      chk("R1 idle after reset", {cpu_ready, bus_req_valid, snp_flush}, 3'd0);

      // R1: every line starts Invalid, so snoops find nothing and a read misses
      for (int i = 0; i < NL; i++) snoop_op(2'd1, i);
      cpu_op(1'b0, 0, 0);

      // processor operations from every start state on every line
      for (int i = 0; i < NL; i++)
         for (int s = 0; s < 3; s++)
            for (int w = 0; w < 2; w++) begin
               set_state(i, 2'(s));
               cpu_op(w[0], i, (i + s) % 3);
               cpu_op(1'b0, i, 0);
            end

      // snooped commands from every start state, then probe the result
      for (int i = 0; i < NL; i++)
         for (int s = 0; s < 3; s++)
            for (int c = 1; c < 4; c++) begin
               set_state(i, 2'(s));
               snoop_op(2'(c), i);
               snoop_op(2'd1, i);
               cpu_op(1'b0, i, 0);
            end

      // R11: snoop kills a pending upgrade, grant later
      set_state(3, 2'd1);
      set_state(2, 2'd1);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 3'd3;
      @(negedge clk); #1;
      chk("R5 upgrade pending", bus_req_cmd, 2'd3);
      snp_valid = 1'b1; snp_cmd = 2'd2; snp_idx = 3'd2; #1;
      chk("R11 other index keeps upgrade", bus_req_cmd, 2'd3);
      @(negedge clk);
      model[2] = 2'd0;
      snp_cmd = 2'd3; snp_idx = 3'd3; #1;
      chk("R11 converted in snoop cycle", {bus_req_cmd, snp_flush}, {2'd2, 1'b0});
      @(negedge clk);
      snp_valid = 1'b0; #1;
      chk("R11 conversion kept", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd2});
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0; bus_done = 1'b1; #1;
      chk("R11 completion", {cpu_ready, cpu_hit}, 2'b10);
      @(negedge clk);
      bus_done = 1'b0; cpu_req_valid = 1'b0;
      model[3] = 2'd2;
      snoop_op(2'd1, 3);
      snoop_op(2'd1, 2);

      // R11: kill and grant in the same cycle
      set_state(4, 2'd1);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 3'd4;
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = 2'd3; snp_idx = 3'd4; bus_grant = 1'b1; #1;
      chk("R11 grant with kill", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd2});
      @(negedge clk);
      snp_valid = 1'b0; bus_grant = 1'b0; bus_done = 1'b1; #1;
      chk("R11 completion with grant", cpu_ready, 1'b1);
      @(negedge clk);
      bus_done = 1'b0; cpu_req_valid = 1'b0;
      model[4] = 2'd2;
      cpu_op(1'b1, 4, 0);

      // R12: read and snooped read on a Modified line in one cycle
      set_state(1, 2'd2);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b0; cpu_req_idx = 3'd1;
      snp_valid = 1'b1; snp_cmd = 2'd1; snp_idx = 3'd1; #1;
      chk("R12 read with snoop read", {snp_flush, cpu_ready, cpu_hit}, 3'b111);
      @(negedge clk);
      snp_valid = 1'b0; cpu_req_valid = 1'b0;
      model[1] = 2'd1;
      cpu_op(1'b1, 1, 0);

      // R12: write and snooped upgrade on a Shared line in one cycle
      set_state(5, 2'd1);
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_write = 1'b1; cpu_req_idx = 3'd5;
      snp_valid = 1'b1; snp_cmd = 2'd3; snp_idx = 3'd5; #1;
      chk("R12 write with snoop upgrade", {snp_flush, cpu_ready}, 2'b00);
      @(negedge clk);
      snp_valid = 1'b0; #1;
      chk("R12 refetch issued", {bus_req_valid, bus_req_cmd}, {1'b1, 2'd2});
      bus_grant = 1'b1;
      @(negedge clk);
      bus_grant = 1'b0; bus_done = 1'b1; #1;
      chk("R12 completion", cpu_ready, 1'b1);
      @(negedge clk);
      bus_done = 1'b0; cpu_req_valid = 1'b0;
      model[5] = 2'd2;
      snoop_op(2'd2, 5);

      repeat (2) @(negedge clk);
      report();
      $finish;
   end

endmodule